// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 interrupt request lines and turns them into two active-low processor inputs: a normal request line and a fast request line. Every source owns a small priority field and a full-width handler address. Software unmasks sources one bit at a time, fetches the handler address of the best pending source with a single register read, and closes each handler with an end-of-interrupt write. The read also acknowledges the source. A handler can therefore be interrupted by a source of strictly higher priority, and the end-of-interrupt write unwinds one nesting level at a time.

Source 0 is wired to the fast request line and has its own vector fetch register. Sources 1 and up compete through the priority logic for the normal line. Each request line is latched on its own, so a one-cycle pulse is held until it is acknowledged. Register accesses use a simple strobe bus. Read data appears one cycle after the read strobe. A read strobe and a write strobe are never given in the same cycle.

Top module: `vic_top`

## Requirements
- R1: After reset both request outputs are high (inactive), the enable mask reads 0 and every priority field reads 0.
- R2: A write to offset 0x120 sets the enable bits that are 1 in the data, a write to 0x124 clears them, and a read of 0x120 returns the mask with bit n belonging to source n.
- R3: A source whose enable bit is 0 never drives either request output low, but its request stays latched and is served once it is enabled.
- R4: The mode register of source n at 0x000+4n holds its priority in bits 2:0 (0 lowest, 7 highest, upper bits read 0), and the vector register at 0x080+4n holds a 32-bit handler address. Both read back as written.
- R5: Among enabled, pending sources not in service, the highest priority wins and a tie goes to the lowest source number. A read of 0x100 returns the winner's vector.
- R6: A read of 0x100 acknowledges the winner and raises the current level to the winner's priority. The normal request line then goes low again only for a pending source of strictly higher priority; equal priority does not preempt.
- R7: Nesting: an acknowledge taken during a handler stacks the previous level. A write to 0x130 returns to that level, after which sources above it are offered again.
- R8: A write to 0x130 while no handler is active has no effect.
- R9: Source 0 never drives the normal request line. It drives the fast line when enabled and pending, and a read of 0x104 returns its vector and clears its request.
- R10: A read of 0x100 with no eligible source above the current level returns 0 and leaves the level unchanged.
- R11: A request line that rises before clock edge k drives its output low from edge k+1 on: one edge to latch the request and one edge to register the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 32 | Request lines, bit n is source n |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_addr_i | input | 9 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| nirq_o | output | 1 | Normal interrupt request, active low |
| nfiq_o | output | 1 | Fast interrupt request, active low |

## Verification
The vector-fetch acknowledge and the latching of a new, higher-priority request can happen at the same clock edge. The bench issues the read of 0x100 in the same cycle as it raises a priority-6 source while a priority-3 source is waiting. It expects the read to return the priority-3 vector, because the new line is only being latched at that edge. It then expects the normal line to fall again at the next edge, because the newcomer outranks the level just entered. The handler addresses that follow must come back in the right order.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Decoded register access kinds
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_MODE,   // per-source priority field
    ACC_VECT,   // per-source handler address
    ACC_IVEC,   // normal vector fetch and acknowledge
    ACC_FVEC,   // fast vector fetch and acknowledge
    ACC_ENSET,  // enable set / enable readback
    ACC_ENCLR,  // enable clear
    ACC_DONE    // end of interrupt
  } acc_e;

  localparam int unsigned OFS_IVEC  = 32'h100;
  localparam int unsigned OFS_FVEC  = 32'h104;
  localparam int unsigned OFS_ENSET = 32'h120;
  localparam int unsigned OFS_ENCLR = 32'h124;
  localparam int unsigned OFS_DONE  = 32'h130;

endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 32,
  parameter int ADDR_W  = 9,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [VEC_W-1:0]               wdata_i,
  output acc_e                           acc_o,
  output logic [ID_W-1:0]                idx_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
  output logic [NUM_SRC-1:0]             en_o,
  input  logic [ID_W-1:0]                win_id_i,
  output logic [VEC_W-1:0]               vec_win_o,
  output logic [VEC_W-1:0]               vec_fiq_o,
  output logic [VEC_W-1:0]               vec_idx_o
);

  acc_e                            acc;
  logic [ID_W-1:0]                 idx;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic [NUM_SRC-1:0]              en_q;
  logic [VEC_W-1:0]                vec_mem [NUM_SRC];

  // Address decode: two per-source windows, then single registers
  always_comb begin
    acc = ACC_NONE;
    if (addr_i[ADDR_W-1:7] == '0)
      acc = ACC_MODE;
    else if (addr_i[ADDR_W-1:7] == (ADDR_W-7)'(1))
      acc = ACC_VECT;
    else begin
      case (32'(addr_i))
        OFS_IVEC:  acc = ACC_IVEC;
        OFS_FVEC:  acc = ACC_FVEC;
        OFS_ENSET: acc = ACC_ENSET;
        OFS_ENCLR: acc = ACC_ENCLR;
        OFS_DONE:  acc = ACC_DONE;
        default:   acc = ACC_NONE;
      endcase
    end
  end

  assign idx   = addr_i[ID_W+1:2];
  assign acc_o = acc;
  assign idx_o = idx;

  // Priority fields and enable mask carry a reset
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
      en_q   <= '0;
    end else if (wr_i) begin
      case (acc)
        ACC_MODE:  prio_q[idx] <= wdata_i[PRIO_W-1:0];
        ACC_ENSET: en_q <= en_q | wdata_i[NUM_SRC-1:0];
        ACC_ENCLR: en_q <= en_q & ~wdata_i[NUM_SRC-1:0];
        default:   ;
      endcase
    end
  end

  // Handler addresses: plain RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_i && acc == ACC_VECT)
      vec_mem[idx] <= wdata_i;
  end

  assign vec_win_o = vec_mem[win_id_i];
  assign vec_fiq_o = vec_mem[0];
  assign vec_idx_o = vec_mem[idx];
  assign prio_o    = prio_q;
  assign en_o      = en_q;

  a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
    (wr_i && acc == ACC_ENSET) |=>
      ((en_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));

  a_r2_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (wr_i && acc == ACC_ENCLR) |=>
      ((en_q & $past(wdata_i[NUM_SRC-1:0])) == '0));

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             req_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                           win_valid_o,
  output logic [ID_W-1:0]                win_id_o,
  output logic [PRIO_W-1:0]              win_prio_o
);

  // Scan from the top down; ">=" lets a lower number take a tie.
  // Source 0 belongs to the fast line and is skipped.
  always_comb begin
    win_valid_o = 1'b0;
    win_id_o    = '0;
    win_prio_o  = '0;
    for (int i = NUM_SRC - 1; i >= 1; i--) begin
      if (req_i[i] && (!win_valid_o || prio_i[i] >= win_prio_o)) begin
        win_valid_o = 1'b1;
        win_id_o    = ID_W'(i);
        win_prio_o  = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/vic_nest.sv
module vic_nest #(
  parameter int LVL_W  = 4,
  parameter int ID_W   = 5,
  parameter int DEPTH  = 8,
  localparam int ENT_W = LVL_W + ID_W,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic [ID_W-1:0]  push_id_i,
  input  logic             pop_i,
  output logic [LVL_W-1:0] cur_lvl_o,
  output logic [ID_W-1:0]  cur_id_o,
  output logic [CNT_W-1:0] depth_o
);

  logic [ENT_W-1:0] stk_mem [DEPTH];
  logic [LVL_W-1:0] cur_lvl_q;
  logic [ID_W-1:0]  cur_id_q;
  logic [CNT_W-1:0] depth_q;
  logic [IDX_W-1:0] wr_ptr, rd_ptr;
  logic             pop_ok;

  assign wr_ptr = IDX_W'(depth_q);
  assign rd_ptr = IDX_W'(depth_q - CNT_W'(1));
  assign pop_ok = pop_i && !push_i && depth_q != '0;

  always_ff @(posedge clk) begin
    if (push_i)
      stk_mem[wr_ptr] <= {cur_lvl_q, cur_id_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lvl_q <= '0;
      cur_id_q  <= '0;
      depth_q   <= '0;
    end else if (push_i) begin
      cur_lvl_q <= push_lvl_i;
      cur_id_q  <= push_id_i;
      depth_q   <= depth_q + CNT_W'(1);
    end else if (pop_ok) begin
      {cur_lvl_q, cur_id_q} <= stk_mem[rd_ptr];
      depth_q   <= depth_q - CNT_W'(1);
    end
  end

  assign cur_lvl_o = cur_lvl_q;
  assign cur_id_o  = cur_id_q;
  assign depth_o   = depth_q;

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push_i |-> depth_q < CNT_W'(DEPTH));

  a_r6_level_climbs: assert property (@(posedge clk) disable iff (rst)
    push_i |-> push_lvl_i > cur_lvl_q);

  a_r8_empty_pop_holds: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && depth_q == '0) |=> (depth_q == '0 && cur_lvl_q == '0));

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 32,
  parameter int ADDR_W  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [VEC_W-1:0]   bus_wdata_i,
  output logic [VEC_W-1:0]   bus_rdata_o,
  output logic               nirq_o,
  output logic               nfiq_o
);

  localparam int ID_W   = $clog2(NUM_SRC);
  localparam int LVL_W  = PRIO_W + 1;          // level 0 = idle
  localparam int DEPTH  = 1 << PRIO_W;         // one slot per climb
  localparam int CNT_W  = $clog2(DEPTH + 1);

  acc_e                           acc;
  logic [ID_W-1:0]                idx;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [NUM_SRC-1:0]             en;
  logic [VEC_W-1:0]               vec_win, vec_fiq, vec_idx;

  logic [NUM_SRC-1:0] pend_q, insvc_q, elig, clr;
  logic               win_valid;
  logic [ID_W-1:0]    win_id;
  logic [PRIO_W-1:0]  win_prio;
  logic [LVL_W-1:0]   win_lvl, cur_lvl;
  logic [ID_W-1:0]    cur_id;
  logic [CNT_W-1:0]   depth;
  logic               above, grant, eoi, eoi_ok, fiq_hot, fiq_ack;
  logic               nirq_q, nfiq_q;
  logic [VEC_W-1:0]   rdata_q;

  vic_regs #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .acc_o     (acc),
    .idx_o     (idx),
    .prio_o    (prio),
    .en_o      (en),
    .win_id_i  (win_id),
    .vec_win_o (vec_win),
    .vec_fiq_o (vec_fiq),
    .vec_idx_o (vec_idx)
  );

  assign elig = pend_q & en & ~insvc_q;

  vic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req_i       (elig),
    .prio_i      (prio),
    .win_valid_o (win_valid),
    .win_id_o    (win_id),
    .win_prio_o  (win_prio)
  );

  assign win_lvl = {1'b0, win_prio} + LVL_W'(1);
  assign above   = win_valid && (win_lvl > cur_lvl);
  assign grant   = bus_rd_i && acc == ACC_IVEC && above;
  assign eoi     = bus_wr_i && acc == ACC_DONE;
  assign eoi_ok  = eoi && !grant && depth != '0;
  assign fiq_hot = pend_q[0] && en[0];
  assign fiq_ack = bus_rd_i && acc == ACC_FVEC && fiq_hot;

  vic_nest #(.LVL_W(LVL_W), .ID_W(ID_W), .DEPTH(DEPTH)) u_nest (
    .clk        (clk),
    .rst        (rst),
    .push_i     (grant),
    .push_lvl_i (win_lvl),
    .push_id_i  (win_id),
    .pop_i      (eoi),
    .cur_lvl_o  (cur_lvl),
    .cur_id_o   (cur_id),
    .depth_o    (depth)
  );

  // Acknowledge clears the latched request of the served source
  always_comb begin
    clr = '0;
    if (grant)   clr[win_id] = 1'b1;
    if (fiq_ack) clr[0]      = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      insvc_q <= '0;
    end else begin
      pend_q <= (pend_q | irq_req_i) & ~clr;
      if (grant)
        insvc_q[win_id] <= 1'b1;
      else if (eoi_ok)
        insvc_q[cur_id] <= 1'b0;
    end
  end

  // Registered outputs and read data
  always_ff @(posedge clk) begin
    if (rst) begin
      nirq_q  <= 1'b1;
      nfiq_q  <= 1'b1;
      rdata_q <= '0;
    end else begin
      nirq_q <= ~above;
      nfiq_q <= ~fiq_hot;
      if (bus_rd_i) begin
        case (acc)
          ACC_MODE:  rdata_q <= VEC_W'(prio[idx]);
          ACC_VECT:  rdata_q <= vec_idx;
          ACC_IVEC:  rdata_q <= above ? vec_win : '0;
          ACC_FVEC:  rdata_q <= fiq_hot ? vec_fiq : '0;
          ACC_ENSET: rdata_q <= VEC_W'(en);
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign nirq_o      = nirq_q;
  assign nfiq_o      = nfiq_q;
  assign bus_rdata_o = rdata_q;

  a_r3_fiq_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(en[0]) |-> nfiq_o);

  a_r3_winner_enabled: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> en[win_id]);

  a_r9_src0_not_normal: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> win_id != '0);

  a_r5_winner_pending: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (pend_q[win_id] && !insvc_q[win_id]));

  a_r6_served_cleared: assert property (@(posedge clk) disable iff (rst)
    (grant && !irq_req_i[win_id]) |=> !pend_q[$past(win_id)]);

endmodule

// File: tb/sim_vic_top.sv
module sim_vic_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] A_IVEC  = 9'h100;
  localparam logic [8:0] A_FVEC  = 9'h104;
  localparam logic [8:0] A_ENSET = 9'h120;
  localparam logic [8:0] A_ENCLR = 9'h124;
  localparam logic [8:0] A_DONE  = 9'h130;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nirq, nfiq;
  int          checks = 0;
  int          errors = 0;

  vic_top u0 (
    .clk(clk), .rst(rst), .irq_req_i(irq), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .nirq_o(nirq), .nfiq_o(nfiq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] vexp(int n);
    return 32'h1000_0000 + 32'(n) * 32'h10;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [8:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); d = rdata; rd = 1'b0;
  endtask

  task automatic pulse(logic [31:0] m);
    @(negedge clk); irq = m;
    @(negedge clk); irq = '0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic set_prio(int n, logic [2:0] p);
    bus_write(9'(4*n), 32'(p));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 nirq", 32'(nirq), 32'd1);
    check("R1 nfiq", 32'(nfiq), 32'd1);
    bus_read(A_ENSET, d); check("R1 enable mask", d, 32'h0);
    bus_read(9'h014, d);  check("R1 prio of src5", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(9'h00C, 32'h0000_0005);
    bus_read(9'h00C, d); check("R4 mode readback", d, 32'd5);
    bus_write(9'h00C, 32'hFFFF_FFFE);
    bus_read(9'h00C, d); check("R4 upper mode bits dropped", d, 32'd6);
    for (int n = 0; n < 32; n++) bus_write(9'(9'h080 + 4*n), vexp(n));
    bus_read(9'h08C, d); check("R4 vector readback src3", d, vexp(3));
    bus_read(9'h0FC, d); check("R4 vector readback src31", d, vexp(31));
    set_prio(3, 3'd0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    bus_write(A_ENSET, 32'h0000_00F0);
    bus_write(A_ENSET, 32'h0000_0F00);
    bus_read(A_ENSET, d); check("R2 set accumulates", d, 32'h0000_0FF0);
    bus_write(A_ENCLR, 32'h0000_0030);
    bus_read(A_ENSET, d); check("R2 clear removes", d, 32'h0000_0FC0);
    bus_write(A_ENCLR, 32'hFFFF_FFFF);
    bus_read(A_ENSET, d); check("R2 clear all", d, 32'h0);
  endtask

  task automatic t_mask_latency();
    logic [31:0] d;
    pulse(32'h1 << 5);
    repeat (4) begin
      @(negedge clk); check("R3 masked stays quiet", 32'(nirq), 32'd1);
    end
    bus_write(A_ENSET, 32'h1 << 5);
    @(negedge clk); check("R3 latched request served when enabled", 32'(nirq), 32'd0);
    bus_read(A_IVEC, d); check("R3 vector of src5", d, vexp(5));
    @(negedge clk); check("R6 line released after ack", 32'(nirq), 32'd1);
    bus_write(A_DONE, 32'h0);
    bus_write(A_ENSET, 32'h1 << 6);
    pulse(32'h1 << 6);
    check("R11 not yet after latch edge", 32'(nirq), 32'd1);
    @(negedge clk); check("R11 low after output edge", 32'(nirq), 32'd0);
    bus_read(A_IVEC, d); check("R11 vector of src6", d, vexp(6));
    bus_write(A_DONE, 32'h0);
    settle(); check("R8 idle after close", 32'(nirq), 32'd1);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    bus_write(A_ENSET, 32'hFFFF_FFFE);
    set_prio(4, 3'd2); set_prio(9, 3'd6); set_prio(12, 3'd6);
    pulse((32'h1 << 4) | (32'h1 << 9) | (32'h1 << 12));
    settle(); check("R5 request seen", 32'(nirq), 32'd0);
    bus_read(A_IVEC, d); check("R5 tie goes to lower number", d, vexp(9));
    settle(); check("R6 equal priority does not preempt", 32'(nirq), 32'd1);
    bus_write(A_DONE, 32'h0);
    settle(); check("R7 offered again after close", 32'(nirq), 32'd0);
    bus_read(A_IVEC, d); check("R5 second of tie", d, vexp(12));
    bus_write(A_DONE, 32'h0);
    bus_read(A_IVEC, d); check("R5 lower priority last", d, vexp(4));
    bus_write(A_DONE, 32'h0);
    settle(); check("R6 all served", 32'(nirq), 32'd1);
    bus_read(A_IVEC, d); check("R10 empty fetch returns zero", d, 32'h0);
    settle(); check("R10 still idle", 32'(nirq), 32'd1);
  endtask

  task automatic t_nesting();
    logic [31:0] d;
    set_prio(7, 3'd1); set_prio(20, 3'd5); set_prio(8, 3'd1); set_prio(2, 3'd0);
    pulse(32'h1 << 7); settle();
    bus_read(A_IVEC, d); check("R7 outer handler", d, vexp(7));
    settle(); check("R7 quiet inside outer", 32'(nirq), 32'd1);
    pulse(32'h1 << 20); settle();
    check("R7 higher preempts", 32'(nirq), 32'd0);
    bus_read(A_IVEC, d); check("R7 inner handler", d, vexp(20));
    bus_write(A_DONE, 32'h0);
    pulse(32'h1 << 8); settle();
    check("R7 level restored to outer", 32'(nirq), 32'd1);
    bus_write(A_DONE, 32'h0);
    settle(); check("R7 outer closed offers src8", 32'(nirq), 32'd0);
    bus_read(A_IVEC, d); check("R7 src8 vector", d, vexp(8));
    bus_write(A_DONE, 32'h0);
    bus_write(A_DONE, 32'h0);
    settle(); check("R8 extra close leaves idle", 32'(nirq), 32'd1);
    pulse(32'h1 << 2); settle();
    check("R8 lowest priority still offered", 32'(nirq), 32'd0);
    bus_read(A_IVEC, d); check("R8 src2 vector", d, vexp(2));
    bus_write(A_DONE, 32'h0);
  endtask

  task automatic t_fast();
    logic [31:0] d;
    pulse(32'h1); settle();
    check("R3 src0 masked keeps fast line high", 32'(nfiq), 32'd1);
    bus_read(A_FVEC, d); check("R9 masked fast fetch zero", d, 32'h0);
    bus_write(A_ENSET, 32'h1);
    @(negedge clk); check("R9 fast line low", 32'(nfiq), 32'd0);
    check("R9 normal line untouched", 32'(nirq), 32'd1);
    bus_read(A_FVEC, d); check("R9 fast vector", d, vexp(0));
    @(negedge clk); check("R9 fast line released", 32'(nfiq), 32'd1);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    set_prio(10, 3'd3); set_prio(11, 3'd6);
    pulse(32'h1 << 10); settle();
    @(negedge clk); rd = 1'b1; addr = A_IVEC; irq = 32'h1 << 11;
    @(negedge clk); d = rdata; rd = 1'b0; irq = '0;
    check("R6 ack returns waiting source", d, vexp(10));
    @(negedge clk); check("R6 newcomer preempts at once", 32'(nirq), 32'd0);
    bus_read(A_IVEC, d); check("R7 newcomer vector", d, vexp(11));
    bus_write(A_DONE, 32'h0);
    bus_write(A_DONE, 32'h0);
    settle(); check("R7 fully unwound", 32'(nirq), 32'd1);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_enable();
    t_mask_latency();
    t_priority();
    t_nesting();
    t_fast();
    t_same_cycle();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", checks);
    summary();
    $finish;
  end

endmodule